// File: doc/BRIEF.md
# Three-Bit Cell Two-Pass Correction Combiner

This block sits between a page of three-bit memory cells and two outer decoders that are not part of it: a decoder over GF(4), which supplies one error symbol per cell, and a binary decoder, which supplies one error bit per cell for the top-bit page. The block applies both sets of corrections in two passes over a page of `CELLS` cells.

In the first pass the block takes each received triplet together with its GF(4) error symbol. It rewrites the triplet on the assumption that exactly one of its three bits flipped. It then forwards the corrected top bit to the binary decoder and stores both the received and the rewritten triplet in an internal page buffer. In the second pass it takes one binary error bit per cell and XORs that bit into all three bits of the stored triplet. The final triplets leave in the same order the cells arrived.

The passes are sequenced so that the second pass cannot start until the whole top-bit stream has been delivered. A new page is only taken once the previous one has fully left. If either decoder flags its word as uncorrectable, the page is returned exactly as received, with a failure flag on every cell.

Top module: `tlc_cell_combiner`

## Requirements
- R1: A cell whose error symbol is 0 keeps its received triplet in the first pass. Triplet encoding is bit 2 = top bit, bit 1 = middle bit, bit 0 = low bit.
- R2: A nonzero symbol flips exactly one bit of the triplet. Symbol 2 flips bit 2. Symbol 1 flips bit 1 when bits 1 and 0 are equal, and flips bit 0 otherwise. Symbol 3 flips bit 0 when bits 1 and 0 are equal, and flips bit 1 otherwise.
- R3: For any symbol, the first-pass result for a complemented triplet is the complement of the result for the original triplet.
- R4: During the first pass, `msb_bit` carries bit 2 of each rewritten triplet in arrival order. `msb_last` is high on the `CELLS`-th bit.
- R5: During the second pass, each `out_bits` value equals the cell's first-pass triplet XOR three copies of its `err_bit`. Cells leave in arrival order, and `out_last` is high on the `CELLS`-th cell.
- R6: `err_ready` stays low until every first-pass top bit of the page has been accepted on the `msb_*` port.
- R7: `cell_ready` stays low from the page's last input cell until its last output cell has been taken.
- R8: If `cell_qfail` is high on any first-pass beat, or `err_fail` is high on the error beats, every output cell of the page carries its received triplet with `out_fail` high. Otherwise `out_fail` is low.
- R9: After reset, `cell_ready` is high, while `msb_valid`, `err_ready` and `out_valid` are low.
- R10: While `msb_valid` or `out_valid` is high and its ready is low, that port's data and last flag stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_valid | input | 1 | Received triplet and symbol valid |
| cell_ready | output | 1 | Block accepts a first-pass cell |
| cell_bits | input | 3 | Received triplet (2 top, 1 middle, 0 low) |
| cell_sym | input | 2 | GF(4) error symbol for the cell |
| cell_qfail | input | 1 | GF(4) decoder reports uncorrectable |
| msb_valid | output | 1 | Corrected top bit valid |
| msb_ready | input | 1 | Binary decoder accepts the bit |
| msb_bit | output | 1 | Corrected top bit |
| msb_last | output | 1 | Last top bit of the page |
| err_valid | input | 1 | Binary error bit valid |
| err_ready | output | 1 | Block accepts an error bit |
| err_bit | input | 1 | Per-cell binary error bit |
| err_fail | input | 1 | Binary decoder reports uncorrectable |
| out_valid | output | 1 | Final triplet valid |
| out_ready | input | 1 | Consumer accepts the triplet |
| out_bits | output | 3 | Final triplet |
| out_last | output | 1 | Last cell of the page |
| out_fail | output | 1 | Page returned uncorrected |

## Verification
The bench builds the block with `CELLS = 32`. With that size, one page holds all 8 triplets under all 4 symbols, so the first-pass rewrite is swept exhaustively in a single page. The complement pairs in that page are then compared against each other. Further pages mix error-bit patterns with irregular ready stalls on both output ports, and two pages raise each decoder's failure flag in turn. Expected values come from the flip rule and the XOR rule, evaluated in the bench.

// File: rtl/tlc_comb_pkg.sv
package tlc_comb_pkg;
  localparam int TRIP_W = 3;
  localparam int SYM_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS1,
    ST_WAIT_BIN,
    ST_PASS2,
    ST_DONE
  } pass_state_t;

  typedef struct packed {
    logic [TRIP_W-1:0] rcv;
    logic [TRIP_W-1:0] mid;
  } cell_rec_t;

  localparam int REC_W = 2 * TRIP_W;
endpackage

// File: rtl/tlc_flip_fix.sv
module tlc_flip_fix
  import tlc_comb_pkg::*;
(
  input  logic [TRIP_W-1:0] trip_i,
  input  logic [SYM_W-1:0]  sym_i,
  output logic [TRIP_W-1:0] trip_o
);
  logic [TRIP_W-1:0] hi;
  logic [TRIP_W-1:0] fixed;

  // fold every triplet onto the top-bit-set half, correct there, unfold
  always_comb begin
    hi = trip_i[2] ? trip_i : ~trip_i;
    case ({hi[1:0], sym_i})
      4'b11_01: fixed = 3'b101;
      4'b11_10: fixed = 3'b011;
      4'b11_11: fixed = 3'b110;
      4'b10_01: fixed = 3'b111;
      4'b10_10: fixed = 3'b010;
      4'b10_11: fixed = 3'b100;
      4'b00_01: fixed = 3'b110;
      4'b00_10: fixed = 3'b000;
      4'b00_11: fixed = 3'b101;
      4'b01_01: fixed = 3'b100;
      4'b01_10: fixed = 3'b001;
      4'b01_11: fixed = 3'b111;
      default:  fixed = hi;
    endcase
    trip_o = trip_i[2] ? fixed : ~fixed;
  end
endmodule

// File: rtl/tlc_page_ram.sv
module tlc_page_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 6,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tlc_pass_fsm.sv
module tlc_pass_fsm
  import tlc_comb_pkg::*;
#(
  parameter int CELLS = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_fire,
  input  logic          bin_fire,
  input  logic          msb_busy,
  input  logic          out_busy,
  output pass_state_t   state,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] raddr,
  output logic          in_last,
  output logic          bin_last
);
  localparam logic [AW-1:0] LAST = AW'(CELLS - 1);

  assign in_last  = (wptr == LAST);
  assign bin_last = (rptr == LAST);
  // address of the cell whose record must be ready on the next cycle
  assign raddr = bin_fire ? (bin_last ? '0 : rptr + 1'b1) : rptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      wptr  <= '0;
      rptr  <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_PASS1: begin
          if (in_fire) begin
            if (in_last) begin
              state <= ST_WAIT_BIN;
              wptr  <= '0;
            end else begin
              state <= ST_PASS1;
              wptr  <= wptr + 1'b1;
            end
          end
        end
        ST_WAIT_BIN: begin
          if (!msb_busy) begin
            state <= ST_PASS2;
            rptr  <= '0;
          end
        end
        ST_PASS2: begin
          if (bin_fire) begin
            if (bin_last) begin
              state <= ST_DONE;
              rptr  <= '0;
            end else begin
              rptr <= rptr + 1'b1;
            end
          end
        end
        ST_DONE: begin
          if (!out_busy) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: the second pass never begins with top bits still pending
  a_r6_no_early_pass2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_BIN && msb_busy) |=> (state != ST_PASS2));
endmodule

// File: rtl/tlc_cell_combiner.sv
module tlc_cell_combiner
  import tlc_comb_pkg::*;
#(
  parameter int CELLS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [TRIP_W-1:0] cell_bits,
  input  logic [SYM_W-1:0]  cell_sym,
  input  logic              cell_qfail,
  output logic              msb_valid,
  input  logic              msb_ready,
  output logic              msb_bit,
  output logic              msb_last,
  input  logic              err_valid,
  output logic              err_ready,
  input  logic              err_bit,
  input  logic              err_fail,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TRIP_W-1:0] out_bits,
  output logic              out_last,
  output logic              out_fail
);
  localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1;

  pass_state_t       state;
  logic [AW-1:0]     wptr, rptr, raddr;
  logic              in_last, bin_last;
  logic              in_fire, bin_fire;
  logic [TRIP_W-1:0] fix_trip;
  logic              fail_q, fail_now;
  cell_rec_t         wrec, rrec;
  logic [REC_W-1:0]  rdata;

  assign cell_ready = (state == ST_IDLE || state == ST_PASS1) && (!msb_valid || msb_ready);
  assign err_ready  = (state == ST_PASS2) && (!out_valid || out_ready);
  assign in_fire    = cell_valid && cell_ready;
  assign bin_fire   = err_valid && err_ready;

  tlc_flip_fix u_fix (
    .trip_i (cell_bits),
    .sym_i  (cell_sym),
    .trip_o (fix_trip)
  );

  tlc_pass_fsm #(.CELLS(CELLS), .AW(AW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .in_fire  (in_fire),
    .bin_fire (bin_fire),
    .msb_busy (msb_valid),
    .out_busy (out_valid),
    .state    (state),
    .wptr     (wptr),
    .rptr     (rptr),
    .raddr    (raddr),
    .in_last  (in_last),
    .bin_last (bin_last)
  );

  assign wrec.rcv = cell_bits;
  assign wrec.mid = fix_trip;

  tlc_page_ram #(.DEPTH(CELLS), .WIDTH(REC_W), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (in_fire),
    .waddr (wptr),
    .wdata (wrec),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign rrec = rdata;

  // failure is sticky over a page and cleared by its first cell
  assign fail_now = fail_q | err_fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q <= 1'b0;
    end else if (in_fire) begin
      fail_q <= ((state == ST_IDLE) ? 1'b0 : fail_q) | cell_qfail;
    end else if (bin_fire) begin
      fail_q <= fail_now;
    end
  end

  // first-pass top-bit stream register
  always_ff @(posedge clk) begin
    if (rst) begin
      msb_valid <= 1'b0;
      msb_bit   <= 1'b0;
      msb_last  <= 1'b0;
    end else if (in_fire) begin
      msb_valid <= 1'b1;
      msb_bit   <= fix_trip[2];
      msb_last  <= in_last;
    end else if (msb_ready) begin
      msb_valid <= 1'b0;
    end
  end

  // second-pass output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_last  <= 1'b0;
      out_fail  <= 1'b0;
    end else if (bin_fire) begin
      out_valid <= 1'b1;
      out_bits  <= fail_now ? rrec.rcv : (rrec.mid ^ {TRIP_W{err_bit}});
      out_last  <= bin_last;
      out_fail  <= fail_now;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1: symbol 0 leaves the triplet as received
  a_r1_zero_sym: assert property (@(posedge clk) disable iff (rst)
    (in_fire && cell_sym == 2'd0) |-> (fix_trip == cell_bits));
  // R2: a nonzero symbol changes exactly one bit
  a_r2_one_flip: assert property (@(posedge clk) disable iff (rst)
    (in_fire && cell_sym != 2'd0) |-> ($countones(fix_trip ^ cell_bits) == 1));
  // R6: error bits are not taken while a top bit is pending
  a_r6_err_after_msb: assert property (@(posedge clk) disable iff (rst)
    err_ready |-> !msb_valid);
  // R7: no new page while output cells remain
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cell_ready);
  // R10: stalled ports hold their data
  a_r10_msb_hold: assert property (@(posedge clk) disable iff (rst)
    (msb_valid && !msb_ready) |=> (msb_valid && $stable(msb_bit) && $stable(msb_last)));
  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) && $stable(out_last) && $stable(out_fail)));
endmodule

// File: tb/test_tlc_cell_combiner.sv
`timescale 1ns/1ps
module test_tlc_cell_combiner;
  localparam int CELLS = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cell_valid = 1'b0, cell_qfail = 1'b0;
  logic [2:0] cell_bits = '0;
  logic [1:0] cell_sym = '0;
  logic       msb_ready = 1'b0, err_valid = 1'b0, err_bit = 1'b0, err_fail = 1'b0;
  logic       out_ready = 1'b0;
  logic       cell_ready, msb_valid, msb_bit, msb_last, err_ready;
  logic       out_valid, out_last, out_fail;
  logic [2:0] out_bits;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int tin [CELLS];
  int sin [CELLS];
  int ein [CELLS];
  int qf  [CELLS];
  int ef  [CELLS];
  int obs0 [CELLS];

  always #10 clk = ~clk;

  tlc_cell_combiner #(.CELLS(CELLS)) i_tlc_cell_combiner (
    .clk(clk), .rst(rst),
    .cell_valid(cell_valid), .cell_ready(cell_ready), .cell_bits(cell_bits),
    .cell_sym(cell_sym), .cell_qfail(cell_qfail),
    .msb_valid(msb_valid), .msb_ready(msb_ready), .msb_bit(msb_bit), .msb_last(msb_last),
    .err_valid(err_valid), .err_ready(err_ready), .err_bit(err_bit), .err_fail(err_fail),
    .out_valid(out_valid), .out_ready(out_ready), .out_bits(out_bits),
    .out_last(out_last), .out_fail(out_fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // single-flip rule written arithmetically
  function automatic int flipm(input int t, input int s);
    int r = t;
    bit eq = (((t >> 1) & 1) == (t & 1));
    if (s == 2) r = t ^ 4;
    else if (s == 1) r = eq ? (t ^ 2) : (t ^ 1);
    else if (s == 3) r = eq ? (t ^ 1) : (t ^ 2);
    return r;
  endfunction

  task automatic run_page(input int pg);
    int pi = 0, mi = 0, ei = 0, oi = 0, cyc = 0;
    bit fail = 0, r6bad = 0, r7bad = 0;
    for (int k = 0; k < CELLS; k++) fail = fail | (qf[k] != 0) | (ef[k] != 0);
    while (oi < CELLS && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      cell_valid = (pi < CELLS);
      cell_bits  = 3'(tin[pi % CELLS]);
      cell_sym   = 2'(sin[pi % CELLS]);
      cell_qfail = (pi < CELLS) && (qf[pi % CELLS] != 0);
      msb_ready  = (pg == 0) ? 1'b1 : ((cyc + pg) % 3 != 0);
      err_valid  = (mi == CELLS) && (ei < CELLS) && (cyc % 5 != 2);
      err_bit    = ein[ei % CELLS] != 0;
      err_fail   = (ei < CELLS) && (ef[ei % CELLS] != 0);
      out_ready  = (pg == 0) ? 1'b1 : ((cyc * pg) % 4 != 1);
      #1;
      if (mi < CELLS && err_ready) r6bad = 1;
      if (pi == CELLS && oi < CELLS && cell_ready) r7bad = 1;
      if (msb_valid && msb_ready) begin
        chk(msb_bit == ((flipm(tin[mi], sin[mi]) >> 2) & 1), "R4 msb_bit",
            int'(msb_bit), (flipm(tin[mi], sin[mi]) >> 2) & 1);
        chk(msb_last == (mi == CELLS - 1), "R4 msb_last", int'(msb_last), int'(mi == CELLS - 1));
        mi++;
      end
      if (out_valid && out_ready) begin
        int exp = fail ? tin[oi] : (flipm(tin[oi], sin[oi]) ^ (ein[oi] != 0 ? 7 : 0));
        chk(int'(out_bits) == exp, fail ? "R8 out_bits" : "R5 out_bits", int'(out_bits), exp);
        chk(out_fail == fail, "R8 out_fail", int'(out_fail), int'(fail));
        chk(out_last == (oi == CELLS - 1), "R5 out_last", int'(out_last), int'(oi == CELLS - 1));
        if (pg == 0) obs0[oi] = int'(out_bits);
        oi++;
      end
      if (cell_valid && cell_ready) pi++;
      if (err_valid && err_ready) ei++;
    end
    chk(oi == CELLS, "R5 page complete", oi, CELLS);
    chk(!r6bad, "R6 err_ready early", int'(r6bad), 0);
    chk(!r7bad, "R7 cell_ready during page", int'(r7bad), 0);
    @(negedge clk);
    cell_valid = 0; err_valid = 0; cell_qfail = 0; err_fail = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    msb_ready = 1'b0;
    #1;
    chk(cell_ready == 1'b1, "R9 cell_ready", int'(cell_ready), 1);
    chk(msb_valid == 1'b0, "R9 msb_valid", int'(msb_valid), 0);
    chk(err_ready == 1'b0, "R9 err_ready", int'(err_ready), 0);
    chk(out_valid == 1'b0, "R9 out_valid", int'(out_valid), 0);

    // page 0: every triplet under every symbol (R1, R2), error bits clear
    for (int k = 0; k < CELLS; k++) begin
      tin[k] = k % 8; sin[k] = k / 8; ein[k] = 0; qf[k] = 0; ef[k] = 0;
    end
    run_page(0);
    // R3: complement pairs differ by full complement after the rewrite
    for (int k = 0; k < CELLS; k++) begin
      if (tin[k] < 4)
        chk(obs0[k] == (obs0[k ^ 7] ^ 7), "R3 complement pair", obs0[k], obs0[k ^ 7] ^ 7);
    end
    // R1 explicit: symbol 0 cells came out as received
    for (int k = 0; k < 8; k++) chk(obs0[k] == tin[k], "R1 zero symbol", obs0[k], tin[k]);

    // page 1: mixed pattern, error bits, stalls (R2, R5, R10)
    for (int k = 0; k < CELLS; k++) begin
      tin[k] = (k * 5 + 3) % 8; sin[k] = (k * 3) % 4; ein[k] = (k % 3 == 0) ? 1 : 0;
      qf[k] = 0; ef[k] = 0;
    end
    run_page(1);

    // page 2: GF(4) decoder failure on one beat (R8)
    for (int k = 0; k < CELLS; k++) begin
      tin[k] = k % 8; sin[k] = (k + 1) % 4; ein[k] = k % 2; qf[k] = (k == 5) ? 1 : 0; ef[k] = 0;
    end
    run_page(2);

    // page 3: binary decoder failure on all error beats (R8), then clean page again
    for (int k = 0; k < CELLS; k++) begin
      tin[k] = (k * 7) % 8; sin[k] = k % 4; ein[k] = (k % 4 == 1) ? 1 : 0; qf[k] = 0; ef[k] = 1;
    end
    run_page(3);

    for (int k = 0; k < CELLS; k++) begin
      tin[k] = (k * 3) % 8; sin[k] = (k / 2) % 4; ein[k] = (k % 5 == 0) ? 1 : 0; qf[k] = 0; ef[k] = 0;
    end
    run_page(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule